// File: doc/BRIEF.md
# DMA Channel Control and Status Bank

This block is the control and status register bank for a four-channel DMA engine. Software reaches it through a small word-addressed read/write port. Each channel has an enable bit. Three write-only strobe registers act on a channel: one halts it, one issues a software request and one resets it. The bank tracks two flags per channel. The request-pending flag says the channel has work to service. The busy flag says the channel holds unfinished work, which a halted channel keeps so that it can resume later.

The per-channel sequencers send strobes to the bank when a whole transfer completes, when a bus abort occurs, when a misaligned address is found and when a single element transfer ends. The bank records completion, abort and misalignment in sticky flags that software clears by writing 1. It folds these flags into a three-bit summary word. It drives one interrupt line from the flags that software has enabled.

A halt or a channel reset drops the enable at once. The pending flag is held until the element transfer in flight finishes, so a transfer is never cut partway through an element. A halt leaves the busy flag set, so re-enabling the channel continues the remaining count. A channel reset clears the busy flag as well.

Top module: `dma_chan_status_bank`

## Requirements
- R1: After reset, all enables, pending, busy, interrupt-enable and event flags are zero, the pulse outputs are zero and `irq` is low.
- R2: A write to address 0x0 loads `chan_en` from `reg_wdata`. The same value reads back at 0x0.
- R3: A write with bit n set to address 0x1 (halt) or address 0xA (channel reset) clears `chan_en[n]` on the next cycle. It also raises `halt_pulse[n]` or `clear_pulse[n]`, respectively, for exactly the one cycle after the write. Addresses 0x1, 0x2 and 0xA read as zero.
- R4: A write with bit n set to address 0x2 sets `req_pend[n]` only when `chan_en[n]` is 1. Otherwise the request is dropped. Pending flags read at 0x3.
- R5: `periph_req[n]` sets `req_pend[n]` when `chan_en[n]` is 1 and is ignored otherwise.
- R6: `seq_done[n]` or `seq_abort[n]` clears `req_pend[n]` and the busy flag. When a clear and a new request arrive in the same cycle, the clear wins.
- R7: After a halt or a channel reset of a pending channel, `req_pend[n]` stays set until the next `seq_elem_end[n]` strobe. It reads 0 on the cycle after that strobe.
- R8: Busy flags read at 0x9. A flag is set when a request is accepted. A halt keeps it set, including across re-enable. A channel reset clears it: after the element drains if the channel is pending, or on the next cycle if it is not.
- R9: Abort, done and misalignment flags, at 0x6, 0x7 and 0x8, are set by `seq_abort`, `seq_done` and `seq_misalign`. Writing 1 to a bit clears it. When a hardware set and a clear hit the same bit in the same cycle, the set wins.
- R10: Address 0x5 reads a summary word: bit 0 is the OR of all abort flags, bit 1 is the OR of all done flags and bit 2 is the OR of all misalignment flags.
- R11: Address 0x4 holds per-channel interrupt enables. `irq` is high when any channel has an enabled bit and at least one of its abort, done or misalignment flags set.
- R12: Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 4 | Write data, one bit per channel |
| reg_rdata | output | 4 | Read data, combinational from `reg_addr` |
| periph_req | input | 4 | Peripheral request lines |
| seq_done | input | 4 | Whole transfer finished, per channel |
| seq_abort | input | 4 | Bus abort seen, per channel |
| seq_misalign | input | 4 | Misaligned address seen, per channel |
| seq_elem_end | input | 4 | Single element transfer finished, per channel |
| chan_en | output | 4 | Channel enables |
| req_pend | output | 4 | Pending request flags |
| halt_pulse | output | 4 | One-cycle halt strobe to the sequencers |
| clear_pulse | output | 4 | One-cycle reset strobe to the sequencers |
| irq | output | 1 | Interrupt |

## Verification
A write or strobe that is sampled on one rising edge shows on `chan_en`, `req_pend`, the pulse outputs and the flag registers right after that same edge. `irq` and `reg_rdata` follow combinationally from those registers, so they carry the new value in the same cycle. Inputs are driven on falling edges, and a behavioural model in the bench updates on every rising edge. The bench compares the model with the outputs on the following falling edge, every cycle. Register reads set the address on a falling edge and sample shortly afterwards. The deferred pending clear of R7 is checked before and after the element-end strobe, so that one cycle of lateness or earliness shows.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'h0;
    localparam logic [ADDR_W-1:0] A_HALT    = 4'h1;
    localparam logic [ADDR_W-1:0] A_KICK    = 4'h2;
    localparam logic [ADDR_W-1:0] A_PEND    = 4'h3;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 4'h4;
    localparam logic [ADDR_W-1:0] A_SUMMARY = 4'h5;
    localparam logic [ADDR_W-1:0] A_FAULT   = 4'h6;
    localparam logic [ADDR_W-1:0] A_DONE    = 4'h7;
    localparam logic [ADDR_W-1:0] A_MISAL   = 4'h8;
    localparam logic [ADDR_W-1:0] A_BUSY    = 4'h9;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 4'hA;

    localparam int unsigned SUM_ABORT = 0;
    localparam int unsigned SUM_DONE  = 1;
    localparam int unsigned SUM_ALIGN = 2;

    typedef struct packed {
        logic en;
        logic pend;
        logic busy;
        logic drain;
        logic rdrain;
    } chan_state_t;
endpackage

// File: rtl/dcs_w1c.sv
module dcs_w1c #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } w1c_state_t;

    w1c_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.flags = set_i | (st_q.flags & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.flags;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & $past(set_i)) == $past(set_i))); // R9
    AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0)); // R9
endmodule

// File: rtl/dcs_chan.sv
module dcs_chan
    import dcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic halt,
    input  logic reset_ch,
    input  logic kick,
    input  logic preq,
    input  logic seq_done,
    input  logic seq_abort,
    input  logic elem_end,
    output logic en_o,
    output logic pend_o,
    output logic busy_o
);
    chan_state_t st_d, st_q;
    logic stop, req, fin, drain_end;

    always_comb begin
        st_d      = st_q;
        stop      = halt | reset_ch;
        req       = st_q.en & (kick | preq) & ~stop;
        fin       = seq_done | seq_abort;
        drain_end = st_q.drain & elem_end;

        // enable: a software write, overridden by halt or reset
        if (en_wr) st_d.en = en_val;
        if (stop)  st_d.en = 1'b0;

        // pending: clear events beat new requests
        if (fin || drain_end) st_d.pend = 1'b0;
        else if (req)         st_d.pend = 1'b1;

        // busy: kept across a halt, dropped by a channel reset
        if (fin)                          st_d.busy = 1'b0;
        else if (drain_end && st_q.rdrain) st_d.busy = 1'b0;
        else if (reset_ch && !st_q.pend)  st_d.busy = 1'b0;
        else if (req)                     st_d.busy = 1'b1;

        // drain: wait for the element in flight before dropping pending
        if (stop && st_q.pend && !fin) begin
            st_d.drain  = 1'b1;
            st_d.rdrain = reset_ch;
        end else if (st_q.drain && (elem_end || fin)) begin
            st_d.drain  = 1'b0;
            st_d.rdrain = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign busy_o = st_q.busy;

    AST_STOP_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt || reset_ch) |=> !en_o); // R3
    AST_KICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !pend_o) |=> !pend_o); // R4
    AST_FIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done || seq_abort) |=> (!pend_o && !busy_o)); // R6
    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && (halt || reset_ch) && !seq_done && !seq_abort && !elem_end) |=> pend_o); // R7
    AST_HALT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && halt && !reset_ch && !seq_done && !seq_abort) |=> busy_o); // R8
endmodule

// File: rtl/dma_chan_status_bank.sv
module dma_chan_status_bank
    import dcs_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    reg_wdata,
    output logic [NCH-1:0]    reg_rdata,
    input  logic [NCH-1:0]    periph_req,
    input  logic [NCH-1:0]    seq_done,
    input  logic [NCH-1:0]    seq_abort,
    input  logic [NCH-1:0]    seq_misalign,
    input  logic [NCH-1:0]    seq_elem_end,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    req_pend,
    output logic [NCH-1:0]    halt_pulse,
    output logic [NCH-1:0]    clear_pulse,
    output logic              irq
);
    localparam int unsigned SUM_W = 3;

    typedef struct packed {
        logic [NCH-1:0] halt_p;
        logic [NCH-1:0] clr_p;
        logic [NCH-1:0] irq_en;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NCH-1:0] wv_enable, wv_halt, wv_kick, wv_clear;
    logic [NCH-1:0] wv_fault, wv_done, wv_misal;
    logic [NCH-1:0] busy, f_abort, f_done, f_misal;
    logic [SUM_W-1:0] summary;

    always_comb begin
        wv_enable = (reg_wr && reg_addr == A_ENABLE) ? reg_wdata : '0;
        wv_halt   = (reg_wr && reg_addr == A_HALT)   ? reg_wdata : '0;
        wv_kick   = (reg_wr && reg_addr == A_KICK)   ? reg_wdata : '0;
        wv_clear  = (reg_wr && reg_addr == A_CLEAR)  ? reg_wdata : '0;
        wv_fault  = (reg_wr && reg_addr == A_FAULT)  ? reg_wdata : '0;
        wv_done   = (reg_wr && reg_addr == A_DONE)   ? reg_wdata : '0;
        wv_misal  = (reg_wr && reg_addr == A_MISAL)  ? reg_wdata : '0;
    end

    always_comb begin
        st_d        = st_q;
        st_d.halt_p = wv_halt;
        st_d.clr_p  = wv_clear;
        if (reg_wr && reg_addr == A_IRQEN) st_d.irq_en = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        dcs_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_wr    (reg_wr && reg_addr == A_ENABLE),
            .en_val   (wv_enable[n]),
            .halt     (wv_halt[n]),
            .reset_ch (wv_clear[n]),
            .kick     (wv_kick[n]),
            .preq     (periph_req[n]),
            .seq_done (seq_done[n]),
            .seq_abort(seq_abort[n]),
            .elem_end (seq_elem_end[n]),
            .en_o     (chan_en[n]),
            .pend_o   (req_pend[n]),
            .busy_o   (busy[n])
        );
    end

    dcs_w1c #(.W(NCH)) u_abort (
        .clk(clk), .rst_n(rst_n), .set_i(seq_abort),    .clr_i(wv_fault), .q_o(f_abort));
    dcs_w1c #(.W(NCH)) u_done (
        .clk(clk), .rst_n(rst_n), .set_i(seq_done),     .clr_i(wv_done),  .q_o(f_done));
    dcs_w1c #(.W(NCH)) u_misal (
        .clk(clk), .rst_n(rst_n), .set_i(seq_misalign), .clr_i(wv_misal), .q_o(f_misal));

    always_comb begin
        summary            = '0;
        summary[SUM_ABORT] = |f_abort;
        summary[SUM_DONE]  = |f_done;
        summary[SUM_ALIGN] = |f_misal;
    end

    assign irq         = |(st_q.irq_en & (f_abort | f_done | f_misal));
    assign halt_pulse  = st_q.halt_p;
    assign clear_pulse = st_q.clr_p;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE:  reg_rdata = chan_en;
            A_PEND:    reg_rdata = req_pend;
            A_IRQEN:   reg_rdata = st_q.irq_en;
            A_SUMMARY: reg_rdata[SUM_W-1:0] = summary;
            A_FAULT:   reg_rdata = f_abort;
            A_DONE:    reg_rdata = f_done;
            A_MISAL:   reg_rdata = f_misal;
            A_BUSY:    reg_rdata = busy;
            default:   reg_rdata = '0;
        endcase
    end

    AST_HALT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_HALT) |=>
            (halt_pulse == $past(reg_wdata)) && ((chan_en & $past(reg_wdata)) == '0)); // R3
    AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR) |=>
            (clear_pulse == $past(reg_wdata)) && ((chan_en & $past(reg_wdata)) == '0)); // R3
    AST_PULSE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_HALT) |=> (halt_pulse == '0)); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.irq_en != '0)); // R11
endmodule

// File: tb/dma_chan_status_bank_tb.sv
module dma_chan_status_bank_tb;
    localparam int  NCH    = 4;
    localparam time CLK_PER = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [NCH-1:0] reg_wdata = '0;
    logic [NCH-1:0] reg_rdata;
    logic [NCH-1:0] periph_req = '0, seq_done = '0, seq_abort = '0;
    logic [NCH-1:0] seq_misalign = '0, seq_elem_end = '0;
    logic [NCH-1:0] chan_en, req_pend, halt_pulse, clear_pulse;
    logic irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    dma_chan_status_bank #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .seq_done(seq_done), .seq_abort(seq_abort), .seq_misalign(seq_misalign),
        .seq_elem_end(seq_elem_end), .chan_en(chan_en), .req_pend(req_pend),
        .halt_pulse(halt_pulse), .clear_pulse(clear_pulse), .irq(irq));

    // behavioural reference model
    bit m_en[NCH], m_pend[NCH], m_busy[NCH], m_drain[NCH], m_rst[NCH];
    bit m_done[NCH], m_abt[NCH], m_mis[NCH], m_ie[NCH], m_hp[NCH], m_cp[NCH];

    function automatic logic [NCH-1:0] pack(input bit v[NCH]);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = v[i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_en[i] = 0; m_pend[i] = 0; m_busy[i] = 0; m_drain[i] = 0; m_rst[i] = 0;
                m_done[i] = 0; m_abt[i] = 0; m_mis[i] = 0; m_ie[i] = 0; m_hp[i] = 0; m_cp[i] = 0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                bit wb, h, c, k, stop, req, fin, de, old_pend;
                wb = reg_wr && reg_wdata[i];
                h  = wb && reg_addr == 4'h1;
                c  = wb && reg_addr == 4'hA;
                k  = wb && reg_addr == 4'h2;
                stop = h || c;
                req  = m_en[i] && (k || periph_req[i]) && !stop;
                fin  = seq_done[i] || seq_abort[i];
                de   = m_drain[i] && seq_elem_end[i];
                old_pend = m_pend[i];
                if (reg_wr && reg_addr == 4'h0) m_en[i] = reg_wdata[i];
                if (stop) m_en[i] = 0;
                if (fin || de) m_pend[i] = 0;
                else if (req) m_pend[i] = 1;
                if (fin) m_busy[i] = 0;
                else if (de && m_rst[i]) m_busy[i] = 0;
                else if (c && !old_pend) m_busy[i] = 0;
                else if (req) m_busy[i] = 1;
                if (stop && old_pend && !fin) begin
                    m_drain[i] = 1; m_rst[i] = c;
                end else if (m_drain[i] && (seq_elem_end[i] || fin)) begin
                    m_drain[i] = 0; m_rst[i] = 0;
                end
                m_done[i] = seq_done[i]     || (m_done[i] && !(wb && reg_addr == 4'h7));
                m_abt[i]  = seq_abort[i]    || (m_abt[i]  && !(wb && reg_addr == 4'h6));
                m_mis[i]  = seq_misalign[i] || (m_mis[i]  && !(wb && reg_addr == 4'h8));
                if (reg_wr && reg_addr == 4'h4) m_ie[i] = reg_wdata[i];
                m_hp[i] = h;
                m_cp[i] = c;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            bit mi;
            mi = 0;
            for (int i = 0; i < NCH; i++) mi |= m_ie[i] && (m_done[i] || m_abt[i] || m_mis[i]);
            check("R2 chan_en",     chan_en,     pack(m_en));
            check("R4 req_pend",    req_pend,    pack(m_pend));
            check("R3 halt_pulse",  halt_pulse,  pack(m_hp));
            check("R3 clear_pulse", clear_pulse, pack(m_cp));
            check("R11 irq",        irq,         mi);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [NCH-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [NCH-1:0] exp, input string tag);
        @(negedge clk); reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic strobe(input int which, input logic [NCH-1:0] v);
        @(negedge clk);
        case (which)
            0: periph_req = v;
            1: seq_done = v;
            2: seq_abort = v;
            3: seq_misalign = v;
            default: seq_elem_end = v;
        endcase
        @(negedge clk);
        periph_req = '0; seq_done = '0; seq_abort = '0; seq_misalign = '0; seq_elem_end = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); cmp_on = 1'b1;
        // R1 reset state
        rd(4'h0, 4'b0000, "R1 enable");
        rd(4'h3, 4'b0000, "R1 pending");
        rd(4'h9, 4'b0000, "R1 busy");
        rd(4'h5, 4'b0000, "R1 summary");
        check("R1 irq", irq, 0);
        // R2
        wr(4'h0, 4'b0101);
        rd(4'h0, 4'b0101, "R2 enable readback");
        // R4 software request gated by enable
        wr(4'h2, 4'b1111);
        rd(4'h3, 4'b0101, "R4 kick gated");
        rd(4'h9, 4'b0101, "R8 busy set");
        rd(4'h2, 4'b0000, "R3 kick reads zero");
        // R5 peripheral request
        strobe(0, 4'b0010);
        rd(4'h3, 4'b0101, "R5 preq ignored when disabled");
        wr(4'h0, 4'b0111);
        strobe(0, 4'b0010);
        rd(4'h3, 4'b0111, "R5 preq accepted");
        // R3 / R7 halt drains
        wr(4'h1, 4'b0001);
        check("R3 halt pulse", halt_pulse, 4'b0001);
        check("R3 halt clears enable", chan_en, 4'b0110);
        rd(4'h3, 4'b0111, "R7 pending held");
        rd(4'h1, 4'b0000, "R3 halt reads zero");
        strobe(4, 4'b0001);
        rd(4'h3, 4'b0110, "R7 pending cleared after element");
        rd(4'h9, 4'b0111, "R8 halt keeps busy");
        wr(4'h0, 4'b0111);
        rd(4'h9, 4'b0111, "R8 busy across re-enable");
        // channel reset of pending ch2
        wr(4'hA, 4'b0100);
        check("R3 clear pulse", clear_pulse, 4'b0100);
        rd(4'h3, 4'b0110, "R7 reset pending held");
        rd(4'hA, 4'b0000, "R3 clear reads zero");
        strobe(4, 4'b0100);
        rd(4'h9, 4'b0011, "R8 reset clears busy");
        // R6 / R9 / R10 / R11
        strobe(1, 4'b0010);
        rd(4'h3, 4'b0000, "R6 done clears pending");
        rd(4'h7, 4'b0010, "R9 done flag");
        rd(4'h5, 4'b0010, "R10 summary done");
        check("R11 irq off", irq, 0);
        wr(4'h4, 4'b0010);
        check("R11 irq on", irq, 1);
        rd(4'h4, 4'b0010, "R11 enable readback");
        @(negedge clk); seq_abort = 4'b0001; seq_misalign = 4'b1000;
        @(negedge clk); seq_abort = '0; seq_misalign = '0;
        rd(4'h6, 4'b0001, "R9 abort flag");
        rd(4'h8, 4'b1000, "R9 misalign flag");
        rd(4'h5, 4'b0111, "R10 summary all");
        rd(4'h9, 4'b0000, "R6 abort clears busy");
        wr(4'h7, 4'b0010);
        rd(4'h7, 4'b0000, "R9 write one clears");
        check("R11 irq after clear", irq, 0);
        rd(4'h6, 4'b0001, "R9 other flag untouched");
        // set wins over clear
        @(negedge clk); reg_wr = 1; reg_addr = 4'h7; reg_wdata = 4'b0010; seq_done = 4'b0010;
        @(negedge clk); reg_wr = 0; reg_wdata = '0; seq_done = '0;
        rd(4'h7, 4'b0010, "R9 set wins");
        // clear beats request in same cycle
        wr(4'h0, 4'b1111);
        @(negedge clk); reg_wr = 1; reg_addr = 4'h2; reg_wdata = 4'b1000; seq_done = 4'b1000;
        @(negedge clk); reg_wr = 0; reg_wdata = '0; seq_done = '0;
        rd(4'h3, 4'b0000, "R6 clear beats request");
        // R12 unmapped
        wr(4'hF, 4'b1111);
        rd(4'hF, 4'b0000, "R12 unmapped reads zero");
        rd(4'h0, 4'b1111, "R12 write ignored");
        // R8 reset of an idle but busy channel
        wr(4'h2, 4'b0001);
        wr(4'h1, 4'b0001);
        strobe(4, 4'b0001);
        rd(4'h9, 4'b0001, "R8 paused busy");
        wr(4'hA, 4'b0001);
        rd(4'h9, 4'b0000, "R8 idle reset clears busy");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule